// File: doc/BRIEF.md
# Staged Mapping Control Register File

This block is a bank of sixteen single-bit control registers on an 8-bit processor bus. A memory decoder elsewhere uses these bits to choose which regions it maps. The register is selected by a four-bit index taken from address bits 19:16. Only data bit 7 carries register content. On reads, bits 6:0 repeat the bus's open-bus value, which is the last data seen on the bus.

Writes to the mapping registers do not reach the decoder directly. They land in a staging copy. A dirty flag records whether any staged bit now differs from the bit the decoder sees. A write to a dedicated commit index copies the whole staging copy into the live copy at once. The commit only takes place when the dirty flag is set, so repeated writes of unchanged values never disturb the decoder.

Two indices serve an interrupt. One holds an interrupt flag, which an external ready strobe sets and a write clears. The other holds an interrupt enable.

Top module: `stage_map_regs`

## Requirements
- R1: After reset, `live_map` equals 16'hCBEF, meaning every bit is 1 except bits 4, 10, 12 and 13. The interrupt flag, the interrupt enable and the dirty flag are all 0, and the staging copy equals `live_map`.
- R2: During a read (`cs`=1, `we`=0), `rdata[7]` depends on the index. Index 0 returns the interrupt flag. Index 1 returns the interrupt enable. Indices 14 and 15 return 0. Any other index n returns `live_map[n]`. The read path is combinational.
- R3: During a read, `rdata[6:0]` equals `mdr[6:0]`.
- R4: A write to index 0 clears the interrupt flag whatever the data. A `ready` pulse sets the flag at the next edge. If both happen in the same cycle, the set wins.
- R5: A write to index 1 loads the interrupt enable from `wdata[7]`. `irq` is high exactly when both the flag and the enable are 1.
- R6: A write to index 2 through 13 stores `wdata[7]` in the staging copy only. `live_map` and the value read back are unchanged.
- R7: A write to index 14 while the dirty flag is set copies all sixteen staging bits into `live_map` at the next edge, and clears the dirty flag.
- R8: The dirty flag is set only when a staged write's bit differs from the live bit, and it stays set until a commit. A write to index 14 while the dirty flag is clear changes nothing.
- R9: A write to index 15 has no effect on any state.
- R10: `live_map` changes only at the clock edge that follows a commit write made while dirty, or during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Bus access strobe for this block |
| we | input | 1 | 1 = write, 0 = read, qualified by `cs` |
| addr | input | 4 | Address bits 19:16, the register index |
| wdata | input | 8 | Write data; only bit 7 is used |
| mdr | input | 8 | Open-bus value; bits 6:0 are returned on reads |
| ready | input | 1 | Ready strobe that sets the interrupt flag |
| rdata | output | 8 | Read data |
| live_map | output | 16 | Live mapping bits, sent to the decoder |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples `rdata` one time unit after it drives the read, before the next rising edge. Every write, commit and ready pulse reaches `live_map` and `irq` on the first rising edge after it is driven. The bench therefore checks those outputs at the following falling edge, against a model it advanced at that same edge. The bench also checks read data after staged writes, which exposes any leak of staging content into the live path before a commit.

// File: rtl/stage_map_regs.sv
module stage_map_regs #(
  parameter int NREG = 16,
  parameter int DATA_W = 8,
  parameter int IDX_LSB = 16,
  parameter logic [NREG-1:0] RESET_MAP = 16'hCBEF,
  parameter int ACK_IDX = 0,
  parameter int EN_IDX = 1,
  parameter int FIRST_MAP = 2,
  parameter int LAST_MAP = 13,
  parameter int COMMIT_IDX = 14,
  localparam int IDX_W = $clog2(NREG),
  localparam int DBIT = DATA_W - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs,
  input  logic                      we,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB] addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [DATA_W-1:0]         mdr,
  input  logic                      ready,
  output logic [DATA_W-1:0]         rdata,
  output logic [NREG-1:0]           live_map,
  output logic                      irq
);

  logic [IDX_W-1:0] idx;
  logic             wbit;
  logic [NREG-1:0]  live_q, shadow_q;
  logic             dirty_q, flag_q, en_q;
  logic             wr, map_wr, commit, rd_bit;
  logic             unused_bits;

  assign idx    = addr;
  assign wbit   = wdata[DBIT];
  assign wr     = cs & we;
  assign map_wr = wr && (idx >= IDX_W'(FIRST_MAP)) && (idx <= IDX_W'(LAST_MAP));
  assign commit = wr && (idx == IDX_W'(COMMIT_IDX)) && dirty_q;
  assign unused_bits = ^{wdata[DBIT-1:0], mdr[DBIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= RESET_MAP;
    else if (map_wr) shadow_q[idx] <= wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= RESET_MAP;
    else if (commit) live_q <= shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              dirty_q <= 1'b0;
    else if (commit)                         dirty_q <= 1'b0;
    else if (map_wr && wbit != live_q[idx])  dirty_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               flag_q <= 1'b0;
    else if (ready)                           flag_q <= 1'b1;
    else if (wr && idx == IDX_W'(ACK_IDX))    flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               en_q <= 1'b0;
    else if (wr && idx == IDX_W'(EN_IDX))     en_q <= wbit;
  end

  always_comb begin
    if (idx == IDX_W'(ACK_IDX))          rd_bit = flag_q;
    else if (idx == IDX_W'(EN_IDX))      rd_bit = en_q;
    else if (idx > IDX_W'(LAST_MAP))     rd_bit = 1'b0;
    else                                 rd_bit = live_q[idx];
  end

  assign rdata    = {rd_bit, mdr[DBIT-1:0]};
  assign live_map = live_q;
  assign irq      = flag_q & en_q;

endmodule

// File: rtl/stage_map_regs_chk.sv
module stage_map_regs_chk #(
  parameter int NREG = 16,
  parameter int IDX_W = 4,
  parameter int ACK_IDX = 0,
  parameter int EN_IDX = 1,
  parameter int FIRST_MAP = 2,
  parameter int LAST_MAP = 13,
  parameter int COMMIT_IDX = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             we,
  input logic [IDX_W-1:0] idx,
  input logic             wbit,
  input logic             ready,
  input logic             rbit,
  input logic [NREG-1:0]  live,
  input logic [NREG-1:0]  shadow,
  input logic             dirty,
  input logic             flag,
  input logic             en,
  input logic             irq
);

  p_ro_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && idx > IDX_W'(LAST_MAP)) |-> !rbit);

  p_ready_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> flag);

  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && idx == IDX_W'(ACK_IDX) && !ready) |=> !flag);

  p_en_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && idx == IDX_W'(EN_IDX)) |=> (en == $past(wbit)));

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && flag));

  p_stage_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && idx >= IDX_W'(FIRST_MAP) && idx <= IDX_W'(LAST_MAP)) |=> $stable(live));

  p_commit_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && idx == IDX_W'(COMMIT_IDX) && dirty) |=> (live == $past(shadow)));

  p_commit_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && idx == IDX_W'(COMMIT_IDX)) |=> !dirty);

  p_ignore_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && idx == IDX_W'(NREG-1) && !ready) |=> ($stable(live) && $stable(shadow) && $stable(flag) && $stable(en)));

  p_live_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live) |-> $past(cs && we && idx == IDX_W'(COMMIT_IDX) && dirty));

endmodule

bind stage_map_regs stage_map_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .idx(idx), .wbit(wbit),
  .ready(ready), .rbit(rdata[7]), .live(live_q), .shadow(shadow_q),
  .dirty(dirty_q), .flag(flag_q), .en(en_q), .irq(irq)
);

// File: tb/sim_stage_map_regs.sv
module sim_stage_map_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RST_MAP = 16'hCBEF;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, we = 1'b0, ready = 1'b0;
  logic [19:16] addr = '0;
  logic [7:0] wdata = '0, mdr = '0, rdata;
  logic [15:0] live_map;
  logic irq;

  int checks = 0, errors = 0;
  logic [15:0] m_live, m_shadow;
  logic m_dirty, m_flag, m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  stage_map_regs u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .mdr(mdr), .ready(ready), .rdata(rdata), .live_map(live_map), .irq(irq));

  function automatic logic exp_bit(input logic [3:0] i);
    if (i == 4'd0) return m_flag;
    if (i == 4'd1) return m_en;
    if (i >= 4'd14) return 1'b0;
    return m_live[i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_live = RST_MAP; m_shadow = RST_MAP; m_dirty = 0; m_flag = 0; m_en = 0;
  endtask

  task automatic model_step(input logic c, input logic w, input logic [3:0] i,
                            input logic b, input logic rdy);
    if (rdy) m_flag = 1;
    else if (c && w && i == 4'd0) m_flag = 0;
    if (c && w && i == 4'd1) m_en = b;
    if (c && w && i >= 4'd2 && i <= 4'd13) begin
      if (b != m_live[i]) m_dirty = 1;
      m_shadow[i] = b;
    end
    if (c && w && i == 4'd14 && m_dirty) begin
      m_live = m_shadow;
      m_dirty = 0;
    end
  endtask

  task automatic cyc(input string tag, input logic c, input logic w, input logic [3:0] i,
                     input logic b, input logic rdy, input logic [7:0] m);
    cs = c; we = w; addr = i; wdata = {b, 7'($urandom)}; ready = rdy; mdr = m;
    #1;
    if (c && !w) begin
      check("R2 read bit", 32'(rdata[7]), 32'(exp_bit(i)));
      check("R3 open bus", 32'(rdata[6:0]), 32'(m[6:0]));
    end
    @(posedge clk);
    model_step(c, w, i, b, rdy);
    @(negedge clk);
    cs = 0; we = 0; ready = 0;
    check({tag, " live_map"}, 32'(live_map), 32'(m_live));
    check("R5 irq", 32'(irq), 32'(m_flag & m_en));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset live_map", 32'(live_map), 32'(RST_MAP));
    check("R1 reset irq", 32'(irq), 32'd0);
    for (int i = 0; i < 16; i++) cyc("R1", 1, 0, 4'(i), 0, 0, 8'($urandom));

    cyc("R6", 1, 1, 4'd4, 1, 0, 8'h00);
    cyc("R6", 1, 0, 4'd4, 0, 0, 8'h7F);
    check("R6 staged bit hidden", 32'(live_map[4]), 32'd0);
    cyc("R7", 1, 1, 4'd14, 0, 0, 8'h00);
    check("R7 commit applied", 32'(live_map[4]), 32'd1);

    cyc("R8", 1, 1, 4'd2, 1, 0, 8'h00);
    cyc("R8", 1, 1, 4'd14, 0, 0, 8'h00);
    cyc("R8", 1, 1, 4'd3, 0, 0, 8'h00);
    cyc("R8", 1, 1, 4'd3, 1, 0, 8'h00);
    cyc("R8", 1, 1, 4'd14, 0, 0, 8'h00);

    cyc("R9", 1, 1, 4'd15, 0, 0, 8'h00);
    cyc("R9", 1, 1, 4'd14, 0, 0, 8'h00);
    cyc("R9", 1, 0, 4'd15, 0, 0, 8'hFF);
    cyc("R9", 1, 0, 4'd1, 0, 0, 8'h55);

    cyc("R5", 1, 1, 4'd1, 1, 0, 8'h00);
    cyc("R4", 0, 0, 4'd0, 0, 1, 8'h00);
    check("R4 ready sets irq", 32'(irq), 32'd1);
    cyc("R4", 1, 1, 4'd0, 1, 0, 8'h00);
    check("R4 ack clears", 32'(irq), 32'd0);
    cyc("R4", 1, 1, 4'd0, 0, 1, 8'h00);
    check("R4 set wins", 32'(irq), 32'd1);

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ri;
      ri = 4'($urandom);
      if (($urandom % 4) == 0) ri = 4'd14;
      cyc("R10", ($urandom % 8) != 0, $urandom % 2 == 1, ri, $urandom % 2 == 1,
          ($urandom % 8) == 0, 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule